// File: doc/BRIEF.md
# Floating-point min/max unit

A single-precision minimum/maximum execution unit for a processor datapath. Each issued operation carries two binary32 operands, an operation select (minimum or maximum) and a semantics select. The semantics select picks one of three ways of treating NaN operands and the two signed zeros: a NaN-propagating mode with ordered zeros, an IEEE 754-2008 minNum/maxNum mode that avoids quiet NaNs but turns signaling NaNs into a quiet NaN, and a plain compare-and-select mode that behaves like a ternary on a less-than or greater-than compare.

The unit returns either one of the two operands unchanged or the canonical quiet NaN 0x7FC00000, together with an invalid-operation flag that reports signaling NaN inputs. One registered stage sits between the operands and the result. A valid strobe travels with the data. Operand fields are parameters, so the same datapath elaborates for other exponent and fraction widths.

Top module: `fminmax_unit`

## Requirements
- R1: In mode 2'b00, if either operand is a NaN (exponent all ones, fraction nonzero), quiet or signaling, the result is the canonical quiet NaN 0x7FC00000.
- R2: In mode 2'b00, -0 orders below +0: minimum of +0 and -0 gives 0x80000000 and maximum gives 0x00000000, whatever the operand order.
- R3: In modes 2'b00 and 2'b01, non-NaN operands are ordered by their sign-magnitude bit patterns, with subnormals compared exactly and -0 below +0. The result is always one of the two operand patterns.
- R4: In mode 2'b01, a quiet NaN (fraction bit 22 set) paired with a non-NaN operand returns the non-NaN operand.
- R5: In mode 2'b01, a signaling NaN in either operand, or NaNs in both operands, gives the canonical quiet NaN 0x7FC00000.
- R6: In mode 2'b10, minimum returns a when a < b, else b; maximum returns a when a > b, else b. The compare treats +0 and -0 as equal, so equal operands return the second operand b.
- R7: In mode 2'b10, any NaN operand makes the compare false, so b is returned bit for bit, payload included.
- R8: The invalid flag is 1 exactly when at least one operand is a signaling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear), in every mode.
- R9: Mode 2'b11 behaves exactly like mode 2'b00.
- R10: The result, the flag and out_valid appear on the clock edge after in_valid is sampled high. out_valid is low after any cycle with in_valid low.
- R11: A synchronous active-high reset clears out_valid on the next clock edge. op_max=0 selects minimum and op_max=1 selects maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and selects are valid this cycle |
| op_max | input | 1 | 0 = minimum, 1 = maximum |
| mode | input | 2 | 00 NaN-propagating, 01 minNum/maxNum, 10 compare-select, 11 as 00 |
| opa | input | 32 | First operand (a) |
| opb | input | 32 | Second operand (b) |
| out_valid | output | 1 | Result and flag are valid |
| result | output | 32 | Selected operand or canonical quiet NaN |
| invalid | output | 1 | Signaling NaN seen on an operand |

## Verification
Every cycle, the in-RTL properties check the following:
- out_valid follows in_valid by one edge, and reset clears it.
- The flag tracks signaling NaN inputs.
- NaN inputs yield the canonical NaN in the propagating and minNum modes.
- A non-NaN pair always yields one of the two input patterns.

The properties cannot tell whether the correct operand was chosen. Only the bench's scenarios show that:
- the signed-zero ordering in each mode, in both operand orders;
- sign-magnitude ordering across subnormals, infinities and negative values;
- the second-operand rule of compare-select;
- the quiet-NaN avoidance of minNum/maxNum.

A sweep over a set of special values crosses every mode and operation against an independent key-based model.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
   typedef enum logic [1:0] {
      MODE_PROP = 2'b00,
      MODE_NUM  = 2'b01,
      MODE_CMP  = 2'b10,
      MODE_RSVD = 2'b11
   } mm_mode_e;

   typedef struct packed {
      logic is_nan;
      logic is_snan;
      logic is_zero;
   } fp_class_t;
endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
   import fpmm_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int W = 1 + EXP_W + MAN_W
) (
   input  logic [W-1:0] val,
   output fp_class_t    cls
);
   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] frac_f;
   logic             exp_max;

   assign exp_f   = val[W-2 -: EXP_W];
   assign frac_f  = val[MAN_W-1:0];
   assign exp_max = &exp_f;

   always_comb begin
      cls.is_nan  = exp_max && (frac_f != '0);
      cls.is_snan = cls.is_nan && !frac_f[MAN_W-1];
      cls.is_zero = (val[W-2:0] == '0);
   end
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order #(
   parameter int W             = 32,
   parameter bit ZEROS_ORDERED = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         lt
);
   logic raw_lt;
   logic mag_lt;
   logic mag_gt;

   assign mag_lt = a[W-2:0] < b[W-2:0];
   assign mag_gt = a[W-2:0] > b[W-2:0];

   always_comb begin
      if (a[W-1] != b[W-1]) raw_lt = a[W-1];
      else if (a[W-1])      raw_lt = mag_gt;
      else                  raw_lt = mag_lt;
   end

   generate
      if (ZEROS_ORDERED) begin : g_total
         assign lt = raw_lt;
      end else begin : g_ieee
         logic both_zero;
         assign both_zero = (a[W-2:0] == '0) && (b[W-2:0] == '0);
         assign lt = raw_lt && !both_zero;
      end
   endgenerate
endmodule

// File: rtl/fpmm_select.sv
module fpmm_select
   import fpmm_pkg::*;
#(
   parameter int          W    = 32,
   parameter logic [W-1:0] QNAN = 32'h7FC0_0000
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  fp_class_t    ca,
   input  fp_class_t    cb,
   input  logic         ord_lt_ab,
   input  logic         ord_lt_ba,
   input  logic         ieee_lt_ab,
   input  logic         ieee_lt_ba,
   input  logic         op_max,
   input  mm_mode_e     mode,
   output logic [W-1:0] res,
   output logic         inv
);
   logic         any_nan;
   logic         both_nan;
   logic         any_snan;
   logic [W-1:0] ordered_pick;
   logic [W-1:0] cmp_pick;

   assign any_nan  = ca.is_nan | cb.is_nan;
   assign both_nan = ca.is_nan & cb.is_nan;
   assign any_snan = ca.is_snan | cb.is_snan;
   assign inv      = any_snan;

   always_comb begin
      if (op_max) ordered_pick = ord_lt_ba ? a : b;
      else        ordered_pick = ord_lt_ab ? a : b;
      if (op_max) cmp_pick = (ieee_lt_ba && !any_nan) ? a : b;
      else        cmp_pick = (ieee_lt_ab && !any_nan) ? a : b;
   end

   always_comb begin
      case (mode)
         MODE_NUM: begin
            if (any_snan || both_nan) res = QNAN;
            else if (ca.is_nan)       res = b;
            else if (cb.is_nan)       res = a;
            else                      res = ordered_pick;
         end
         MODE_CMP: res = cmp_pick;
         default:  res = any_nan ? QNAN : ordered_pick;
      endcase
   end
endmodule

// File: rtl/fminmax_unit.sv
module fminmax_unit
   import fpmm_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int W = 1 + EXP_W + MAN_W
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic         op_max,
   input  logic [1:0]   mode,
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   output logic         out_valid,
   output logic [W-1:0] result,
   output logic         invalid
);
   localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   generate
      if (EXP_W < 2 || MAN_W < 2) begin : g_param_bad
         $error("fminmax_unit: EXP_W and MAN_W must each be at least 2");
      end
   endgenerate

   logic [W-1:0] ops [2];
   fp_class_t    cls [2];
   logic         ord_lt_ab, ord_lt_ba, ieee_lt_ab, ieee_lt_ba;
   logic [W-1:0] res_d;
   logic         inv_d;
   mm_mode_e     mode_e;

   assign ops[0] = opa;
   assign ops[1] = opb;
   assign mode_e = mm_mode_e'(mode);

   generate
      for (genvar i = 0; i < 2; i++) begin : g_cls
         fpmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .val (ops[i]),
            .cls (cls[i])
         );
      end
   endgenerate

   fpmm_order #(.W(W), .ZEROS_ORDERED(1'b1)) u_ord_ab  (.a(opa), .b(opb), .lt(ord_lt_ab));
   fpmm_order #(.W(W), .ZEROS_ORDERED(1'b1)) u_ord_ba  (.a(opb), .b(opa), .lt(ord_lt_ba));
   fpmm_order #(.W(W), .ZEROS_ORDERED(1'b0)) u_ieee_ab (.a(opa), .b(opb), .lt(ieee_lt_ab));
   fpmm_order #(.W(W), .ZEROS_ORDERED(1'b0)) u_ieee_ba (.a(opb), .b(opa), .lt(ieee_lt_ba));

   fpmm_select #(.W(W), .QNAN(QNAN)) u_sel (
      .a          (opa),
      .b          (opb),
      .ca         (cls[0]),
      .cb         (cls[1]),
      .ord_lt_ab  (ord_lt_ab),
      .ord_lt_ba  (ord_lt_ba),
      .ieee_lt_ab (ieee_lt_ab),
      .ieee_lt_ba (ieee_lt_ba),
      .op_max     (op_max),
      .mode       (mode_e),
      .res        (res_d),
      .inv        (inv_d)
   );

   always_ff @(posedge clk) begin
      if (rst) out_valid <= 1'b0;
      else     out_valid <= in_valid;
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         result  <= res_d;
         invalid <= inv_d;
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R10
   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid); // R10
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> !out_valid); // R11
   AST_FLAG_SNAN: assert property (@(posedge clk) disable iff (rst)
      in_valid && (cls[0].is_snan || cls[1].is_snan) |=> invalid); // R8
   AST_FLAG_CLEAN: assert property (@(posedge clk) disable iff (rst)
      in_valid && !cls[0].is_snan && !cls[1].is_snan |=> !invalid); // R8
   AST_PROP_NAN: assert property (@(posedge clk) disable iff (rst)
      in_valid && (mode == 2'b00 || mode == 2'b11) && (cls[0].is_nan || cls[1].is_nan)
      |=> result == QNAN); // R1
   AST_NUM_SNAN: assert property (@(posedge clk) disable iff (rst)
      in_valid && mode == 2'b01 && (cls[0].is_snan || cls[1].is_snan)
      |=> result == QNAN); // R5
   AST_PICK_OPERAND: assert property (@(posedge clk) disable iff (rst)
      in_valid && !cls[0].is_nan && !cls[1].is_nan
      |=> (result == $past(opa) || result == $past(opb))); // R3
endmodule

// File: tb/tb_fminmax_unit.sv
module tb_fminmax_unit;
   localparam logic [31:0] QN = 32'h7FC0_0000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        op_max = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic        out_valid;
   logic [31:0] result;
   logic        invalid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] res;
      logic        inv;
      string       tag;
   } exp_t;
   exp_t sbq[$];

   always #4 clk = ~clk;

   fminmax_unit dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_max(op_max), .mode(mode),
      .opa(opa), .opb(opb), .out_valid(out_valid), .result(result), .invalid(invalid)
   );

   function automatic bit m_nan(logic [31:0] x);
      return (x[30:23] == 8'hFF) && (x[22:0] != 0);
   endfunction
   function automatic bit m_snan(logic [31:0] x);
      return m_nan(x) && !x[22];
   endfunction
   function automatic logic [31:0] m_key(logic [31:0] x);
      return x[31] ? ~x : (x | 32'h8000_0000);
   endfunction

   function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b, logic mx, logic [1:0] md);
      logic [1:0] m = (md == 2'b11) ? 2'b00 : md;
      logic [31:0] pick;
      if (mx) pick = (m_key(a) > m_key(b)) ? a : b;
      else    pick = (m_key(a) < m_key(b)) ? a : b;
      if (m == 2'b00) return (m_nan(a) || m_nan(b)) ? QN : pick;
      if (m == 2'b01) begin
         if (m_snan(a) || m_snan(b) || (m_nan(a) && m_nan(b))) return QN;
         if (m_nan(a)) return b;
         if (m_nan(b)) return a;
         return pick;
      end
      if (m_nan(a) || m_nan(b) || (a[30:0] == 0 && b[30:0] == 0)) return b;
      return pick;
   endfunction

   task automatic send(logic [31:0] a, logic [31:0] b, logic mx, logic [1:0] md,
                       logic [31:0] exp_res, string tag);
      exp_t e;
      @(negedge clk);
      opa = a; opb = b; op_max = mx; mode = md; in_valid = 1'b1;
      e.res = exp_res;
      e.inv = m_snan(a) || m_snan(b);
      e.tag = tag;
      sbq.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   always @(negedge clk) begin
      if (!rst && out_valid) begin
         checks++;
         if (sbq.size() == 0) begin
            errors++;
            $display("FAIL R10 out_valid without request: actual 1 expected 0");
         end else begin
            exp_t e;
            e = sbq.pop_front();
            if (result !== e.res || invalid !== e.inv) begin
               errors++;
               $display("FAIL %s result %08h inv %0b expected %08h inv %0b",
                        e.tag, result, invalid, e.res, e.inv);
            end
         end
      end
   end

   initial begin
      repeat (30000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] vals [13] = '{32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 32'hBF80_0000,
                                 32'h4000_0000, 32'h0000_0001, 32'h8000_0001, 32'h007F_FFFF,
                                 32'h7F80_0000, 32'hFF80_0000, 32'h7FC0_0001, 32'h7F80_0001,
                                 32'hC020_0000};
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++; $display("FAIL R11 out_valid in reset: actual %0b expected 0", out_valid);
      end
      @(negedge clk); rst = 1'b0;

      // R1 NaN propagation
      send(32'h3F80_0000, 32'h7FC1_2345, 0, 2'b00, QN, "R1 min num,qnan");
      send(32'h7F80_0001, 32'h4000_0000, 1, 2'b00, QN, "R1 R8 max snan,num");
      // R2 ordered zeros
      send(32'h0000_0000, 32'h8000_0000, 0, 2'b00, 32'h8000_0000, "R2 min +0,-0");
      send(32'h8000_0000, 32'h0000_0000, 0, 2'b00, 32'h8000_0000, "R2 min -0,+0");
      send(32'h0000_0000, 32'h8000_0000, 1, 2'b00, 32'h0000_0000, "R2 max +0,-0");
      send(32'h8000_0000, 32'h0000_0000, 1, 2'b00, 32'h0000_0000, "R2 max -0,+0");
      // R3 sign-magnitude ordering
      send(32'h0000_0001, 32'h0000_0002, 0, 2'b00, 32'h0000_0001, "R3 subnormal min");
      send(32'hBF80_0000, 32'hC000_0000, 1, 2'b00, 32'hBF80_0000, "R3 negative max");
      send(32'h8000_0001, 32'h0000_0001, 0, 2'b01, 32'h8000_0001, "R3 signed subnormal");
      // R4 quiet NaN avoided
      send(32'h7FC0_0000, 32'h3F80_0000, 0, 2'b01, 32'h3F80_0000, "R4 min qnan,num");
      send(32'hBF80_0000, 32'h7FFF_FFFF, 1, 2'b01, 32'hBF80_0000, "R4 max num,qnan");
      // R5 signaling NaN or two NaNs
      send(32'h3F80_0000, 32'h7F80_0001, 0, 2'b01, QN, "R5 min num,snan");
      send(32'h7FC0_0005, 32'hFFC0_0000, 1, 2'b01, QN, "R5 max qnan,qnan");
      // R6 compare-select
      send(32'h0000_0000, 32'h8000_0000, 0, 2'b10, 32'h8000_0000, "R6 min +0,-0 gives b");
      send(32'h8000_0000, 32'h0000_0000, 0, 2'b10, 32'h0000_0000, "R6 min -0,+0 gives b");
      send(32'h0000_0000, 32'h8000_0000, 1, 2'b10, 32'h8000_0000, "R6 max +0,-0 gives b");
      send(32'h3F80_0000, 32'h4000_0000, 0, 2'b10, 32'h3F80_0000, "R6 min 1,2");
      send(32'h3F80_0000, 32'h4000_0000, 1, 2'b10, 32'h4000_0000, "R6 max 1,2");
      send(32'h4000_0000, 32'h3F80_0000, 0, 2'b10, 32'h3F80_0000, "R6 R11 min 2,1");
      // R7 NaN in compare-select returns b
      send(32'h7FC1_2345, 32'h3F80_0000, 0, 2'b10, 32'h3F80_0000, "R7 min nan,num");
      send(32'h3F80_0000, 32'h7FC1_2345, 0, 2'b10, 32'h7FC1_2345, "R7 min num,nan");
      send(32'h3F80_0000, 32'h7F80_0001, 1, 2'b10, 32'h7F80_0001, "R7 R8 max num,snan");
      // R9 reserved mode
      send(32'h0000_0000, 32'h8000_0000, 0, 2'b11, 32'h8000_0000, "R9 min zeros");
      send(32'h7FC0_0000, 32'h3F80_0000, 0, 2'b11, QN, "R9 min qnan,num");

      // R10 bubble
      idle();
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++; $display("FAIL R10 out_valid after idle: actual %0b expected 0", out_valid);
      end

      // R3 sweep against the model (R8 flag checked on every item)
      for (int i = 0; i < 13; i++)
         for (int j = 0; j < 13; j++)
            for (int k = 0; k < 8; k++)
               send(vals[i], vals[j], k[0], k[2:1],
                    model(vals[i], vals[j], k[0], k[2:1]), "R3 sweep");
      idle();
      @(negedge clk);

      // R11 reset mid-stream
      @(negedge clk);
      opa = 32'h3F80_0000; opb = 32'h0; in_valid = 1'b1; rst = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      checks++;
      if (out_valid !== 1'b0) begin
         errors++; $display("FAIL R11 out_valid after reset: actual %0b expected 0", out_valid);
      end
      rst = 1'b0;
      repeat (2) @(negedge clk);
      checks++;
      if (sbq.size() != 0) begin
         errors++; $display("FAIL R10 missing results: actual %0d pending expected 0", sbq.size());
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule